// File: doc/BRIEF.md
# Presettable Cascadable Binary Up-Counter

This block is a synchronous binary up-counter built from a chain of 4-bit stages. All stage registers share one rising clock edge, so every bit of the count moves in the same cycle. A low level on the clear input empties the counter at once, with no wait for the clock. A low level on the preset input at a clock edge copies a parallel value into the counter. Otherwise the counter advances by one when both of its enables are high, and holds its value when either enable is low.

The two enables have different jobs. `cnt_en` goes to every stage and only gates counting. `chain_en` enters the lowest stage and also gates the carry output. Inside the chain, each stage's carry drives the next stage's `chain_en`. Because of this, no outside gating is needed to count across all stages. The carry output of the top stage lets the whole chain feed a further chain of the same kind. The parameter `STAGES` sets how many 4-bit stages there are.

Top module: `cnt_chain`

## Requirements
- R1: When `clear_n` is low, `count` becomes 0 at once, even between clock edges and whatever the levels of `preset_n`, `cnt_en` and `chain_en`. It stays 0 while `clear_n` is low.
- R2: When `preset_n` is low at a rising clock edge and `clear_n` is high, `count` takes `preset_val` after that edge, whatever the levels of `cnt_en` and `chain_en`.
- R3: When `preset_n`, `cnt_en` and `chain_en` are all high at a rising edge, `count` goes up by exactly one.
- R4: When `preset_n` is high and either `cnt_en` or `chain_en` is low at a rising edge, `count` keeps its value.
- R5: `chain_out` is high exactly when `chain_en` is high and every bit of `count` is 1. It is combinational, so it follows `chain_en` without a clock edge.
- R6: Changes on `preset_n`, `cnt_en` or `chain_en` between edges leave `count` unchanged until the next rising edge.
- R7: Counting from the all-ones value gives 0. A full run of 2^(4*STAGES) increments returns the count to its start value, and `chain_out` is high on exactly one of those cycles.
- R8: A stage at 15 whose lower stages are all at 15 passes a carry into the next stage. For example, with two stages, 0x0F counts to 0x10.
- R9: `cnt_en` reaches every stage. With `cnt_en` low, no stage moves, even a stage whose carry input is high. `chain_out` still depends only on `chain_en` and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Asynchronous clear, active low |
| preset_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable shared by all stages |
| chain_en | input | 1 | Count enable that also gates the carry output |
| preset_val | input | 4*STAGES | Value loaded when `preset_n` is low |
| count | output | 4*STAGES | Current count, stage 0 in the low nibble |
| chain_out | output | 1 | Carry output of the top stage |

## Verification
The assertions check the following on every clock edge:
- the preset, increment and hold rules;
- the definition of the carry;
- that the count is zero while clear is held low.

The increment check also covers wrapping and the carry from one stage into the next.

Some behaviour happens between clock edges, so only the bench's scenarios show it:
- the count dropping to zero in the middle of a cycle;
- the carry following `chain_en` without a clock;
- the single carry pulse over a full run of the counting range.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int NIB_W = 4;
  typedef logic [NIB_W-1:0] nib_t;
  localparam nib_t NIB_MAX = '1;
endpackage

// File: rtl/cnt_nibble_next.sv
module cnt_nibble_next
  import cnt_pkg::*;
(
  input  nib_t cur,
  input  nib_t ld_val,
  input  logic ld_n,
  input  logic step,
  output nib_t nxt
);
  // load first, then increment, then hold
  always_comb begin
    if (!ld_n)      nxt = ld_val;
    else if (step)  nxt = cur + nib_t'(1);
    else            nxt = cur;
  end
endmodule

// File: rtl/cnt_nibble.sv
module cnt_nibble
  import cnt_pkg::*;
(
  input  logic clk,
  input  logic clear_n,
  input  logic preset_n,
  input  logic cnt_en,
  input  logic chain_in,
  input  nib_t ld_val,
  output nib_t val,
  output logic carry
);
  nib_t nxt;

  cnt_nibble_next u_next (
    .cur    (val),
    .ld_val (ld_val),
    .ld_n   (preset_n),
    .step   (cnt_en & chain_in),
    .nxt    (nxt)
  );

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) val <= '0;
    else          val <= nxt;
  end

  assign carry = chain_in & (val == NIB_MAX);
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
  import cnt_pkg::*;
#(
  parameter int STAGES = 2,
  localparam int W = NIB_W * STAGES
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic         preset_n,
  input  logic         cnt_en,
  input  logic         chain_en,
  input  logic [W-1:0] preset_val,
  output logic [W-1:0] count,
  output logic         chain_out
);
  logic [STAGES:0] link;
  assign link[0] = chain_en;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    cnt_nibble u_nib (
      .clk      (clk),
      .clear_n  (clear_n),
      .preset_n (preset_n),
      .cnt_en   (cnt_en),
      .chain_in (link[g]),
      .ld_val   (preset_val[g*NIB_W +: NIB_W]),
      .val      (count[g*NIB_W +: NIB_W]),
      .carry    (link[g+1])
    );
  end

  assign chain_out = link[STAGES];
endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         clear_n,
  input logic         preset_n,
  input logic         cnt_en,
  input logic         chain_en,
  input logic [W-1:0] preset_val,
  input logic [W-1:0] count,
  input logic         chain_out
);
  // low from a clear until the first edge after it; masks cycles a clear cut into
  logic run_ok;
  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) run_ok <= 1'b0;
    else          run_ok <= 1'b1;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) !clear_n |-> count == '0); // R1
  AST_PRESET_TAKES: assert property (@(posedge clk) disable iff (!clear_n || !run_ok)
    !preset_n |=> count == $past(preset_val)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!clear_n || !run_ok)
    (preset_n && cnt_en && chain_en) |=> count == $past(count) + 1'b1); // R3
  AST_HOLD_VAL: assert property (@(posedge clk) disable iff (!clear_n || !run_ok)
    (preset_n && !(cnt_en && chain_en)) |=> $stable(count)); // R4
  AST_CARRY_ONLY_MAX: assert property (@(posedge clk) disable iff (!clear_n)
    chain_out |-> (chain_en && (&count))); // R5
  AST_CARRY_AT_MAX: assert property (@(posedge clk) disable iff (!clear_n)
    (chain_en && (&count)) |-> chain_out); // R5
endmodule

bind cnt_chain cnt_chain_chk #(.W(W)) u_chk (
  .clk(clk), .clear_n(clear_n), .preset_n(preset_n), .cnt_en(cnt_en),
  .chain_en(chain_en), .preset_val(preset_val), .count(count), .chain_out(chain_out)
);

// File: tb/sim_cnt_chain.sv
`timescale 1ns/100ps
module sim_cnt_chain;
  localparam int STAGES = 2;
  localparam int W = 4 * STAGES;

  typedef struct packed {
    logic         ld_n;
    logic         ep;
    logic         et;
    logic [W-1:0] d;
    logic [W-1:0] exp_q;
    logic         exp_c;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b1, 8'hFC, 8'hFC, 1'b0},  // R2 preset
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'hFD, 1'b0},  // R3
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'hFE, 1'b0},  // R3
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1},  // R5 carry at max
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0},  // R7 wrap
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h01, 1'b0},  // R3
    '{1'b1, 1'b0, 1'b1, 8'h00, 8'h01, 1'b0},  // R4 hold
    '{1'b0, 1'b0, 1'b0, 8'h0E, 8'h0E, 1'b0},  // R2 load ignores enables
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h0F, 1'b0},  // R3
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h10, 1'b0},  // R8 stage carry
    '{1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, 1'b0},  // R2, R5 carry gated
    '{1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1},  // R9 shared enable low
    '{1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0},  // R4 chain enable low
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}   // R7
  };

  logic         clk = 1'b0;
  logic         clear_n = 1'b0;
  logic         preset_n = 1'b1;
  logic         cnt_en = 1'b0;
  logic         chain_en = 1'b0;
  logic [W-1:0] preset_val = '0;
  logic [W-1:0] count;
  logic         chain_out;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  cnt_chain #(.STAGES(STAGES)) u0 (
    .clk(clk), .clear_n(clear_n), .preset_n(preset_n), .cnt_en(cnt_en),
    .chain_en(chain_en), .preset_val(preset_val), .count(count), .chain_out(chain_out)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic ld, input logic ep, input logic et, input logic [W-1:0] d);
    @(negedge clk);
    preset_n = ld; cnt_en = ep; chain_en = et; preset_val = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int model;
    int carries;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset count", count, '0);
    check("R1 reset carry", {7'd0, chain_out}, '0);
    @(negedge clk);
    clear_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].ld_n, VECS[i].ep, VECS[i].et, VECS[i].d);
      check($sformatf("R2-R9 vec%0d count", i), count, VECS[i].exp_q);
      check($sformatf("R5 vec%0d carry", i), {7'd0, chain_out}, {7'd0, VECS[i].exp_c});
    end

    // R5: carry follows chain_en without a clock edge
    drive(1'b0, 1'b0, 1'b0, 8'hFF);
    chain_en = 1'b1; #0.3;
    check("R5 carry rises combinationally", {7'd0, chain_out}, 8'd1);
    chain_en = 1'b0; #0.3;
    check("R5 carry falls combinationally", {7'd0, chain_out}, 8'd0);

    // R6: control changes between edges leave the count alone
    drive(1'b0, 1'b1, 1'b1, 8'h33);
    preset_val = 8'h99; preset_n = 1'b1; #0.3;
    cnt_en = 1'b0; #0.3; cnt_en = 1'b1; #0.3;
    check("R6 no change mid-cycle", count, 8'h33);

    // R1: clear in mid-cycle empties the counter at once
    drive(1'b0, 1'b1, 1'b1, 8'h5A);
    check("R1 preload", count, 8'h5A);
    #0.3 clear_n = 1'b0;
    #0.3 check("R1 async clear mid-cycle", count, '0);
    @(posedge clk); #1;
    check("R1 clear beats load at edge", count, '0);
    @(negedge clk); clear_n = 1'b1;
    preset_n = 1'b1; cnt_en = 1'b1; chain_en = 1'b1;
    @(posedge clk); #1;
    check("R3 counts after clear", count, 8'h01);

    // R7: full range from a known start, one carry pulse
    drive(1'b0, 1'b1, 1'b1, 8'h00);
    model = 0;
    carries = 0;
    for (int n = 0; n < (1 << W); n++) begin
      if (chain_out) carries++;
      drive(1'b1, 1'b1, 1'b1, 8'h00);
      model = (model + 1) % (1 << W);
      if (count !== model[W-1:0]) check("R7 full run step", count, model[W-1:0]);
    end
    check("R7 full run returns to start", count, 8'h00);
    check("R7 one carry per full run", carries[W-1:0], 8'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule